// File: doc/BRIEF.md
# Three-Wire Serial RAM Slave

This block is the device side of a 128-byte serial memory. A host reaches it over three lines: an active-high enable, a serial clock and one data line. The data line appears here as a separate input, a driven value and an output enable, so that a pad at a higher level can form the tri-state wire. All three host lines are sampled by a faster system clock, and serial clock edges are found by edge detection.

Each transfer opens when enable rises. The host then sends 24 bits of address/command, least-significant bit first:
- The first byte selects read or write.
- The second byte carries the address.
- The third byte carries a burst flag in its top bit.

Every fixed bit of the command is checked as its byte completes. A mismatch locks the slave out until enable is taken low and high again. A valid command is followed by one data byte. If the address is zero and the burst flag is set, the command is followed instead by a burst through all 128 locations.

Top module: `serial_ram_slave`

## Requirements
- R1: While reset is held or enable is low, `dq_oe` is 0 and `dq_out` is 0. Dropping enable stops any transfer at once, and the next enable rise starts a fresh command.
- R2: A read command has first byte 0x9D (bit 0 first on the wire, all bytes LSB first) and third byte 0x00. It makes the slave drive the byte stored at the second-byte address. Bit k is driven after the k-th serial clock fall that follows the 24th command rise, and `dq_oe` is 1 while it is driven.
- R3: A write command has first byte 0x62, the complement of the read code. It stores the 8 bits sampled on the next 8 serial clock rises at the address in bits 6..0 of the second byte. A set burst flag (third byte bit 7) with a nonzero address still gives a single-byte transfer.
- R4: Any first byte other than 0x9D or 0x62 aborts the cycle. Until enable is cycled, no write happens and `dq_oe` stays 0.
- R5: A second command byte with bit 7 set aborts the cycle with the same lockout as R4.
- R6: A third command byte with any of bits 6..0 set aborts the cycle with the same lockout as R4.
- R7: Address 0 together with burst flag 1 gives a burst. Bytes are written to, or read from, addresses 0, 1, 2 … 127 in order, each byte LSB first.
- R8: After a single-byte transfer, further serial clocks are ignored: no further location is written and `dq_oe` stays 0.
- R9: A write byte that has received fewer than 8 rises when enable falls is discarded. This includes the case where enable falls in the same instant as the eighth rise.
- R10: Dropping enable in the middle of a burst ends it. Bytes already finished remain stored, and the unfinished byte is not stored.
- R11: After burst byte 127, further clocks are ignored: address 0 is not overwritten and `dq_oe` stays 0.
- R12: `dq_oe` is 0 throughout the 24 command clocks and during all write data clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Host enable, active high, asynchronous |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| dq_in | input | 1 | Data line as seen by the slave |
| dq_out | output | 1 | Value the slave drives onto the data line |
| dq_oe | output | 1 | High while the slave drives the data line |

## Verification
Two events can fall in the same system-clock cycle: the eighth rise of a write byte, which would commit the byte, and the loss of enable, which cancels the transfer. The bench provokes this by raising the serial clock and lowering enable in the same time step, so that both pass through the synchronizer together. It judges the outcome by reading the location back and expecting its earlier contents. A second overlap occurs at a burst byte boundary, where the address step and the next byte's first falling edge lie close together. This is judged by reading back all 128 locations of a burst in order.

// File: rtl/sram3w_pkg.sv
// Shared constants and types for the three-wire serial RAM slave.
// Assumes byte-wide commands and data, least-significant bit first.
package sram3w_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 3;
    localparam int CMD_BITS  = CMD_BYTES * BYTE_W;

    // Operation codes as the byte value assembled LSB first.
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h9D;
    localparam logic [BYTE_W-1:0] OP_WRITE = ~OP_READ;

    typedef enum logic [2:0] {
        ST_IDLE,   // enable low, waiting
        ST_CMD,    // shifting the 24 command bits
        ST_DATA,   // moving data bytes
        ST_DONE,   // transfer finished, clocks ignored
        ST_LOCK    // command rejected, clocks ignored
    } ctl_state_t;
endpackage

// File: rtl/sram3w_sync.sv
// Multi-bit input synchronizer: each asynchronous input passes through its
// own chain of STAGES flops clocked by the system clock.
// Assumes the inputs change slowly compared with clk (several clk periods
// per level), so that bits skewed by one cycle are harmless.
module sram3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] pipe;

            // Shift the raw input into the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '0;
                end else begin
                    pipe <= {pipe[STAGES-2:0], async_in[g]};
                end
            end

            assign sync_out[g] = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sram3w_store.sv
// Byte storage: one registered write port and one combinational read port.
// Contents are not reset; the host is expected to write before reading.
module sram3w_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit one byte when the controller pulses the write enable.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sram3w_ctrl.sv
// Transfer controller. Finds serial clock edges in the synchronized clock,
// shifts and checks the 24-bit command byte by byte, then moves single
// bytes or a full burst, and drives the data line only for read bits.
// Assumes en_s, sclk_s and din_s come from the same synchronizer, so that
// a data bit is aligned with the rising edge that samples it.
module sram3w_ctrl
    import sram3w_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dq_out,
    output logic              dq_oe
);
    localparam int CNT_W = $clog2(CMD_BITS);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] END_B1   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] END_B2   = CNT_W'(2 * BYTE_W - 1);
    localparam logic [CNT_W-1:0] END_B3   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] END_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    ctl_state_t        state;
    logic              sclk_q;
    logic              rise, fall;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] byte_in;
    logic              is_read;
    logic              burst;
    logic [ADDR_W-1:0] addr;
    logic              op_ok, addr_hi_ok, flag_lo_ok;

    // Hold the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // Byte completed by the current rising edge, LSB first.
    assign byte_in = {din_s, sh[BYTE_W-1:1]};

    // Field checks on the byte that is completing.
    always_comb begin
        op_ok      = (byte_in == OP_READ) || (byte_in == OP_WRITE);
        addr_hi_ok = (byte_in >> ADDR_W) == '0;
        flag_lo_ok = byte_in[BYTE_W-2:0] == '0;
    end

    // Main sequencer: command intake, data movement, abort and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            is_read <= 1'b0;
            burst   <= 1'b0;
            addr    <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            dq_out  <= 1'b0;
            dq_oe   <= 1'b0;
        end else if (!en_s) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            burst  <= 1'b0;
            wr_en  <= 1'b0;
            dq_out <= 1'b0;
            dq_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    state <= ST_CMD;
                    cnt   <= '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == END_B1) begin
                            if (!op_ok) state <= ST_LOCK;
                            is_read <= (byte_in == OP_READ);
                        end else if (cnt == END_B2) begin
                            if (!addr_hi_ok) state <= ST_LOCK;
                            addr <= byte_in[ADDR_W-1:0];
                        end else if (cnt == END_B3) begin
                            cnt <= '0;
                            if (!flag_lo_ok) begin
                                state <= ST_LOCK;
                            end else begin
                                state <= ST_DATA;
                                burst <= byte_in[BYTE_W-1] && (addr == '0);
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (fall && is_read) begin
                        dq_out <= rd_data[cnt[BIT_W-1:0]];
                        dq_oe  <= 1'b1;
                    end
                    if (rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == END_DATA) begin
                            cnt <= '0;
                            if (!is_read) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr;
                                wr_data <= byte_in;
                            end
                            if (burst && addr != LAST_ADDR) begin
                                addr <= addr + 1'b1;
                            end else begin
                                state  <= ST_DONE;
                                dq_oe  <= 1'b0;
                                dq_out <= 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    // ST_DONE and ST_LOCK: wait for enable to drop.
                    dq_oe  <= 1'b0;
                    dq_out <= 1'b0;
                end
            endcase
        end
    end

    assign rd_addr = addr;

    // R1
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !dq_oe);

    // R12
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (state == ST_DATA && is_read));

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && en_s) |=> state == ST_LOCK);

    // R3
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state == ST_DATA && !is_read && en_s));

    // R7
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && state == ST_DATA && burst && rise && cnt == END_DATA
         && addr != LAST_ADDR) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/serial_ram_slave.sv
// Top level of the three-wire serial RAM slave: synchronizes the host
// lines, runs the transfer controller and holds the byte storage.
// Assumes ADDR_W <= 7 so that the address fits in the second command byte.
module serial_ram_slave #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic dq_in,
    output logic dq_out,
    output logic dq_oe
);
    import sram3w_pkg::*;

    logic [2:0]        raw_lines, sync_lines;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en;

    assign raw_lines = {ser_en, ser_clk, dq_in};

    sram3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    sram3w_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (sync_lines[2]),
        .sclk_s  (sync_lines[1]),
        .din_s   (sync_lines[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    sram3w_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/serial_ram_slave_test.sv
module serial_ram_slave_test;
    localparam int HP = 8;
    localparam logic [7:0] RD = 8'h9D;
    localparam logic [7:0] WR = 8'h62;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, ser_en, ser_clk, dq_in;
    logic dq_out, dq_oe;
    int   checks = 0;
    int   errors = 0;
    bit   cmd_oe_seen;

    serial_ram_slave uut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(bit b);
        ser_clk = 1'b0;
        dq_in   = b;
        tick(HP);
        if (dq_oe) cmd_oe_seen = 1'b1;
        ser_clk = 1'b1;
        tick(HP);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v, output bit oe_all, output bit oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ser_clk = 1'b0;
            tick(HP);
            v[i] = dq_out;
            if (dq_oe) oe_any = 1'b1;
            else       oe_all = 1'b0;
            ser_clk = 1'b1;
            tick(HP);
        end
    endtask

    task automatic start();
        ser_en = 1'b1;
        tick(HP);
    endtask

    task automatic stop();
        ser_en = 1'b0;
        tick(2 * HP);
    endtask

    task automatic send_cmd(logic [7:0] op, logic [7:0] b2, logic [7:0] b3);
        send_byte(op);
        send_byte(b2);
        send_byte(b3);
    endtask

    task automatic write_one(logic [7:0] a, logic [7:0] d);
        start();
        send_cmd(WR, a, 8'h00);
        send_byte(d);
        stop();
    endtask

    task automatic read_one(logic [7:0] a, output logic [7:0] v, output bit oe_all);
        bit any;
        start();
        send_cmd(RD, a, 8'h00);
        recv_byte(v, oe_all, any);
        stop();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ser_en = 1'b0; ser_clk = 1'b0; dq_in = 1'b0;
        tick(5);
        chk("R1 oe in reset", int'(dq_oe), 0);
        chk("R1 dout in reset", int'(dq_out), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 oe after reset", int'(dq_oe), 0);
    endtask

    task automatic t_single();
        logic [7:0] v; bit oe_all;
        cmd_oe_seen = 1'b0;
        write_one(8'h13, 8'h5A);
        chk("R12 oe during write", int'(cmd_oe_seen), 0);
        write_one(8'h7F, 8'hA5);
        cmd_oe_seen = 1'b0;
        read_one(8'h13, v, oe_all);
        chk("R12 oe during read command", int'(cmd_oe_seen), 0);
        chk("R2 read 0x13", int'(v), 8'h5A);
        chk("R2 oe during read bits", int'(oe_all), 1);
        chk("R1 oe after stop", int'(dq_oe), 0);
        read_one(8'h7F, v, oe_all);
        chk("R3 top address", int'(v), 8'hA5);
        // R3: burst flag with nonzero address gives single transfer
        write_one(8'h06, 8'h44);
        start();
        send_cmd(WR, 8'h05, 8'h80);
        send_byte(8'h12);
        send_byte(8'h34);
        stop();
        read_one(8'h05, v, oe_all);
        chk("R3 flag nonzero addr", int'(v), 8'h12);
        read_one(8'h06, v, oe_all);
        chk("R3 no second byte", int'(v), 8'h44);
    endtask

    task automatic t_aborts();
        logic [7:0] v; bit oe_all, any;
        start(); send_cmd(8'h9C, 8'h13, 8'h00); send_byte(8'hFF); stop();
        read_one(8'h13, v, oe_all);
        chk("R4 bad op write ignored", int'(v), 8'h5A);
        start(); send_cmd(8'h9F, 8'h13, 8'h00); recv_byte(v, oe_all, any); stop();
        chk("R4 bad op no drive", int'(any), 0);
        start(); send_cmd(WR, 8'h93, 8'h00); send_byte(8'h00); stop();
        read_one(8'h13, v, oe_all);
        chk("R5 addr bit7 abort", int'(v), 8'h5A);
        start(); send_cmd(WR, 8'h13, 8'h01); send_byte(8'h11); stop();
        read_one(8'h13, v, oe_all);
        chk("R6 byte3 low bit abort", int'(v), 8'h5A);
        start(); send_cmd(RD, 8'h13, 8'h40); recv_byte(v, oe_all, any); stop();
        chk("R6 byte3 abort no drive", int'(any), 0);
        read_one(8'h13, v, oe_all);
        chk("R1 fresh cycle after lock", int'(v), 8'h5A);
    endtask

    task automatic t_extra();
        logic [7:0] v; bit oe_all, any;
        write_one(8'h21, 8'h77);
        start(); send_cmd(WR, 8'h20, 8'h00); send_byte(8'hC3); send_byte(8'h3C); stop();
        read_one(8'h20, v, oe_all);
        chk("R3 write 0x20", int'(v), 8'hC3);
        read_one(8'h21, v, oe_all);
        chk("R8 no write past byte", int'(v), 8'h77);
        start(); send_cmd(RD, 8'h20, 8'h00);
        recv_byte(v, oe_all, any);
        recv_byte(v, oe_all, any);
        stop();
        chk("R8 no drive past byte", int'(any), 0);
    endtask

    task automatic t_partial();
        logic [7:0] v; bit oe_all;
        write_one(8'h30, 8'h99);
        start(); send_cmd(WR, 8'h30, 8'h00);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        stop();
        read_one(8'h30, v, oe_all);
        chk("R9 short write dropped", int'(v), 8'h99);
        // R9: enable falls together with the eighth rise
        start(); send_cmd(WR, 8'h30, 8'h00);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        ser_clk = 1'b0; dq_in = 1'b0;
        tick(HP);
        ser_clk = 1'b1; ser_en = 1'b0;
        tick(2 * HP);
        read_one(8'h30, v, oe_all);
        chk("R9 coincident drop", int'(v), 8'h99);
    endtask

    task automatic t_burst();
        logic [7:0] v; bit oe_all, any;
        int bad = 0;
        start(); send_cmd(WR, 8'h00, 8'h80);
        for (int i = 0; i < 128; i++) send_byte(pat(i));
        send_byte(8'hEE);
        stop();
        start(); send_cmd(RD, 8'h00, 8'h80);
        for (int i = 0; i < 128; i++) begin
            recv_byte(v, oe_all, any);
            if (v != pat(i) || !oe_all) bad++;
            if (i == 0 || i == 1 || i == 127) chk("R7 burst byte", int'(v), int'(pat(i)));
        end
        chk("R7 burst mismatches", bad, 0);
        recv_byte(v, oe_all, any);
        stop();
        chk("R11 no drive after 127", int'(any), 0);
        read_one(8'h00, v, oe_all);
        chk("R11 addr 0 kept", int'(v), int'(pat(0)));
    endtask

    task automatic t_burst_stop();
        logic [7:0] v; bit oe_all, any;
        start(); send_cmd(WR, 8'h00, 8'h80);
        send_byte(8'hA0); send_byte(8'hA1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        stop();
        read_one(8'h01, v, oe_all);
        chk("R10 finished byte kept", int'(v), 8'hA1);
        read_one(8'h02, v, oe_all);
        chk("R10 unfinished byte dropped", int'(v), int'(pat(2)));
        start(); send_cmd(RD, 8'h00, 8'h80);
        recv_byte(v, oe_all, any);
        chk("R10 burst read first", int'(v), 8'hA0);
        for (int i = 0; i < 3; i++) begin
            ser_clk = 1'b0; tick(HP); ser_clk = 1'b1; tick(HP);
        end
        stop();
        chk("R10 oe off after stop", int'(dq_oe), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_aborts();
        t_extra();
        t_partial();
        t_burst();
        t_burst_stop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule